// File: doc/BRIEF.md
# Reset-Link Command Decoder

This block sits behind the receiver of a dedicated reset/control link that runs at 125 MHz. It takes a byte stream qualified by a valid strobe and splits it into commands. Each command starts with an 8-bit code. Depending on the code, a fixed number of payload bytes follows: none, two or four. When a command is complete, the block raises a one-cycle command strobe. The code and the assembled payload are presented in registers alongside the strobe.

A steering filter lets one board be singled out on a shared link. An address command loads a 16-bit target address. From then on, ordinary commands are passed on only if that target equals this board's address or the all-ones broadcast value. A sync command always passes and returns the filter to broadcast. Codes outside the map raise a one-cycle error strobe and are dropped.

Top module: `rstlink_cmd_decoder`

## Requirements
- R1: After reset, `cmd_valid` and `cmd_error` are low and the filter holds broadcast (0xFFFF), so the first command is passed regardless of `board_addr`.
- R2: The codes 0x11, 0x12, 0x13, 0x14, 0x20, 0x21, 0x24, 0x25, 0x26, 0x32 and 0x33 carry no payload. Each one produces `cmd_valid` for exactly the cycle after its code byte is accepted, with `cmd_code` equal to the code and `cmd_payload` equal to zero.
- R3: Code 0x10 is followed by four payload bytes, most significant first. `cmd_valid` is raised in the cycle after the fourth byte is accepted, with `cmd_payload` holding all 32 bits.
- R4: Codes 0x30 and 0x31 are followed by two payload bytes, most significant first. The strobe comes in the cycle after the second byte, and the 16-bit value is zero-extended in `cmd_payload`.
- R5: While a payload is being collected, cycles with `rx_valid` low are ignored. The partial payload is held, and no strobe appears until the last byte arrives.
- R6: A code byte outside the map raises `cmd_error` for one cycle, the cycle after it is accepted. It produces no `cmd_valid`, and the next valid byte is decoded as a new code.
- R7: Code 0x40 is followed by a two-byte address. It is always passed on, and its payload becomes the filter target for the commands that follow it.
- R8: While the filter target is neither `board_addr` nor 0xFFFF, commands other than 0x40 and 0x11 complete silently, with neither `cmd_valid` nor `cmd_error`.
- R9: Code 0x11 is always passed on and returns the filter to broadcast.
- R10: A command is passed when the target equals `board_addr` or equals 0xFFFF.
- R11: Bytes received as payload are never decoded as codes. A payload byte equal to an unknown code raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Byte qualifier |
| rx_byte | input | 8 | Received byte |
| board_addr | input | 16 | This board's address for the steering filter |
| cmd_valid | output | 1 | One-cycle strobe for a complete, passed command |
| cmd_code | output | 8 | Code of the command being strobed |
| cmd_payload | output | 32 | Assembled payload, zero-extended |
| cmd_error | output | 1 | One-cycle strobe for an unknown code |

## Verification
Every result is registered exactly once. `cmd_valid`, `cmd_code`, `cmd_payload` and `cmd_error` therefore change at the clock edge that accepts the final byte of a command, or the unknown code, and they hold for that cycle only. The bench drives each byte half a period before an edge and samples at the falling edge right after the accepting edge. It checks every byte, not only the last one of a command. This confirms that intermediate and gap cycles show no strobe and that the result appears in exactly one cycle. A sweep of all 256 code values compares each result against a length table held in the bench. Directed sequences then cover payload gaps and the steering filter.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
   localparam logic [7:0] OP_RUN_PREP  = 8'h10;
   localparam logic [7:0] OP_SYNC      = 8'h11;
   localparam logic [7:0] OP_RUN_START = 8'h12;
   localparam logic [7:0] OP_RUN_END   = 8'h13;
   localparam logic [7:0] OP_RUN_ABORT = 8'h14;
   localparam logic [7:0] OP_LT_START  = 8'h20;
   localparam logic [7:0] OP_LT_STOP   = 8'h21;
   localparam logic [7:0] OP_ST_START  = 8'h24;
   localparam logic [7:0] OP_ST_STOP   = 8'h25;
   localparam logic [7:0] OP_ST_PROBE  = 8'h26;
   localparam logic [7:0] OP_RST_SET   = 8'h30;
   localparam logic [7:0] OP_RST_CLR   = 8'h31;
   localparam logic [7:0] OP_ENABLE    = 8'h32;
   localparam logic [7:0] OP_DISABLE   = 8'h33;
   localparam logic [7:0] OP_ADDRESS   = 8'h40;

   localparam int LEN_NONE  = 0;
   localparam int LEN_SHORT = 2;
   localparam int LEN_LONG  = 4;

   typedef enum logic [1:0] {
      KIND_BAD   = 2'd0,
      KIND_NONE  = 2'd1,
      KIND_SHORT = 2'd2,
      KIND_LONG  = 2'd3
   } op_kind_e;
endpackage

// File: rtl/rlc_classify.sv
module rlc_classify
   import rlc_pkg::*;
#(
   parameter int CNT_W = 3
) (
   input  logic [7:0]       code,
   output logic             known,
   output logic [CNT_W-1:0] nbytes
);
   op_kind_e kind;

   always_comb begin
      unique case (code)
         OP_RUN_PREP:                                    kind = KIND_LONG;
         OP_RST_SET, OP_RST_CLR, OP_ADDRESS:             kind = KIND_SHORT;
         OP_SYNC, OP_RUN_START, OP_RUN_END, OP_RUN_ABORT,
         OP_LT_START, OP_LT_STOP, OP_ST_START, OP_ST_STOP,
         OP_ST_PROBE, OP_ENABLE, OP_DISABLE:             kind = KIND_NONE;
         default:                                        kind = KIND_BAD;
      endcase
   end

   always_comb begin
      known = (kind != KIND_BAD);
      case (kind)
         KIND_LONG:  nbytes = CNT_W'(LEN_LONG);
         KIND_SHORT: nbytes = CNT_W'(LEN_SHORT);
         default:    nbytes = CNT_W'(LEN_NONE);
      endcase
   end
endmodule

// File: rtl/rlc_payload_asm.sv
module rlc_payload_asm #(
   parameter int DATA_W = 8,
   parameter int MAXB   = 4,
   parameter int CNT_W  = 3,
   localparam int PAY_W = DATA_W * MAXB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  start_len,
   input  logic [DATA_W-1:0] start_code,
   input  logic              byte_en,
   input  logic [DATA_W-1:0] byte_in,
   output logic              busy,
   output logic [DATA_W-1:0] held_code,
   output logic              last,
   output logic [PAY_W-1:0]  word_next
);
   logic [CNT_W-1:0] remain;
   logic [PAY_W-1:0] word;

   assign word_next = {word[PAY_W-DATA_W-1:0], byte_in};
   assign last      = busy && byte_en && (remain == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         remain    <= '0;
         word      <= '0;
         held_code <= '0;
      end else if (start) begin
         busy      <= 1'b1;
         remain    <= start_len;
         word      <= '0;
         held_code <= start_code;
      end else if (busy && byte_en) begin
         word   <= word_next;
         remain <= remain - CNT_W'(1);
         if (remain == CNT_W'(1)) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/rlc_addr_filter.sv
module rlc_addr_filter #(
   parameter int          ADDR_W      = 16,
   parameter logic [15:0] BCAST       = 16'hFFFF,
   parameter bit          MATCH_BCAST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              to_bcast,
   input  logic [ADDR_W-1:0] board_addr,
   output logic              match
);
   localparam logic [ADDR_W-1:0] BC = BCAST[ADDR_W-1:0];
   logic [ADDR_W-1:0] target;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        target <= BC;
      else if (to_bcast) target <= BC;
      else if (load)     target <= load_val;
   end

   generate
      if (MATCH_BCAST) begin : g_bcast
         assign match = (target == board_addr) || (target == BC);
      end else begin : g_exact
         assign match = (target == board_addr);
      end
   endgenerate
endmodule

// File: rtl/rstlink_cmd_decoder.sv
module rstlink_cmd_decoder
   import rlc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int MAXB   = 4,
   parameter int ADDR_W = 16,
   localparam int PAY_W = DATA_W * MAXB,
   localparam int CNT_W = $clog2(MAXB + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic [ADDR_W-1:0] board_addr,
   output logic              cmd_valid,
   output logic [DATA_W-1:0] cmd_code,
   output logic [PAY_W-1:0]  cmd_payload,
   output logic              cmd_error
);
   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("rstlink_cmd_decoder: codes are 8 bits wide");
      end
      if (MAXB < LEN_LONG) begin : g_bad_maxb
         $error("rstlink_cmd_decoder: MAXB too small for longest payload");
      end
      if (ADDR_W > PAY_W || ADDR_W > 16) begin : g_bad_addr
         $error("rstlink_cmd_decoder: ADDR_W out of range");
      end
   endgenerate

   logic              known;
   logic [CNT_W-1:0]  nbytes;
   logic              busy, last;
   logic [DATA_W-1:0] held_code;
   logic [PAY_W-1:0]  word_next;
   logic              match;

   rlc_classify #(.CNT_W(CNT_W)) u_cls (
      .code(rx_byte), .known(known), .nbytes(nbytes)
   );

   logic idle_take, start_pay, fire, pass, bad;
   logic [DATA_W-1:0] fire_code;
   logic [PAY_W-1:0]  fire_pay;

   always_comb begin
      idle_take = rx_valid && !busy;
      start_pay = idle_take && known && (nbytes != '0);
      bad       = idle_take && !known;
      fire      = (idle_take && known && (nbytes == '0)) || last;
      fire_code = busy ? held_code : rx_byte;
      fire_pay  = busy ? word_next : '0;
      pass      = (fire_code == OP_SYNC) || (fire_code == OP_ADDRESS) || match;
   end

   rlc_payload_asm #(.DATA_W(DATA_W), .MAXB(MAXB), .CNT_W(CNT_W)) u_asm (
      .clk(clk), .rst_n(rst_n),
      .start(start_pay), .start_len(nbytes), .start_code(rx_byte),
      .byte_en(rx_valid), .byte_in(rx_byte),
      .busy(busy), .held_code(held_code), .last(last), .word_next(word_next)
   );

   rlc_addr_filter #(.ADDR_W(ADDR_W)) u_flt (
      .clk(clk), .rst_n(rst_n),
      .load(fire && (fire_code == OP_ADDRESS)),
      .load_val(fire_pay[ADDR_W-1:0]),
      .to_bcast(fire && (fire_code == OP_SYNC)),
      .board_addr(board_addr),
      .match(match)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid   <= 1'b0;
         cmd_error   <= 1'b0;
         cmd_code    <= '0;
         cmd_payload <= '0;
      end else begin
         cmd_valid <= fire && pass;
         cmd_error <= bad;
         if (fire && pass) begin
            cmd_code    <= fire_code;
            cmd_payload <= fire_pay;
         end
      end
   end
endmodule

// File: rtl/rlc_checker.sv
module rlc_checker #(
   parameter int PAY_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_valid,
   input logic             cmd_valid,
   input logic [7:0]       cmd_code,
   input logic [PAY_W-1:0] cmd_payload,
   input logic             cmd_error
);
   logic code_none, code_short, code_long;
   always_comb begin
      code_none  = cmd_code inside {8'h11, 8'h12, 8'h13, 8'h14, 8'h20, 8'h21,
                                    8'h24, 8'h25, 8'h26, 8'h32, 8'h33};
      code_short = cmd_code inside {8'h30, 8'h31, 8'h40};
      code_long  = (cmd_code == 8'h10);
   end

   // R2, R3, R4: only mapped codes are ever strobed
   assert_known_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (code_none || code_short || code_long));

   // R2: no-payload commands report zero payload
   assert_zero_payload_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && code_none) |-> (cmd_payload == '0));

   // R4: two-byte payloads are zero-extended
   assert_short_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && code_short) |-> (cmd_payload[PAY_W-1:16] == '0));

   // R6: error and command strobes never coincide
   assert_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_error |-> !cmd_valid);

   // R5: a strobe always follows an accepted byte
   assert_strobe_after_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid || cmd_error) |-> $past(rx_valid));
endmodule

bind rstlink_cmd_decoder rlc_checker #(.PAY_W(PAY_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid),
   .cmd_valid(cmd_valid), .cmd_code(cmd_code),
   .cmd_payload(cmd_payload), .cmd_error(cmd_error)
);

// File: tb/sim_rstlink_cmd_decoder.sv
`timescale 1ns/1ps
module sim_rstlink_cmd_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic [15:0] board_addr = 16'h1234;
   logic        cmd_valid, cmd_error;
   logic [7:0]  cmd_code;
   logic [31:0] cmd_payload;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic        o_v, o_e;
   logic [7:0]  o_c;
   logic [31:0] o_p;

   always #2 clk = ~clk;

   rstlink_cmd_decoder u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .board_addr(board_addr), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_payload(cmd_payload), .cmd_error(cmd_error)
   );

   function automatic int exp_len(input logic [7:0] c);
      case (c)
         8'h10:                                   return 4;
         8'h30, 8'h31, 8'h40:                     return 2;
         8'h11, 8'h12, 8'h13, 8'h14, 8'h20, 8'h21,
         8'h24, 8'h25, 8'h26, 8'h32, 8'h33:       return 0;
         default:                                 return -1;
      endcase
   endfunction

   // drive a byte at a falling edge; sample the registered result one period later
   task automatic send(input logic [7:0] b, input int gap);
      rx_valid = 1'b1;
      rx_byte  = b;
      @(negedge clk);
      o_v = cmd_valid; o_e = cmd_error; o_c = cmd_code; o_p = cmd_payload;
      rx_valid = 1'b0;
      for (int i = 0; i < gap; i++) begin
         @(negedge clk);
         checks++;
         if (cmd_valid || cmd_error) begin
            failures++;
            $display("FAIL R5 gap cycle strobe: valid=%0b error=%0b expected 0/0",
                     cmd_valid, cmd_error);
         end
      end
   endtask

   task automatic expect_obs(input string req, input bit ev, input bit ee,
                             input logic [7:0] ec, input logic [31:0] ep);
      checks++;
      if (o_v !== ev || o_e !== ee || (ev && (o_c !== ec || o_p !== ep))) begin
         failures++;
         $display("FAIL %s: valid=%0b error=%0b code=%h payload=%h expected %0b %0b %h %h",
                  req, o_v, o_e, o_c, o_p, ev, ee, ec, ep);
      end
   endtask

   task automatic expect_quiet(input string req);
      expect_obs(req, 1'b0, 1'b0, 8'h00, 32'h0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0]  b1, b2, b3;
      logic [31:0] ep;
      repeat (3) @(negedge clk);
      // R1 reset state
      checks++;
      if (cmd_valid !== 1'b0 || cmd_error !== 1'b0) begin
         failures++;
         $display("FAIL R1 reset outputs: valid=%0b error=%0b expected 0 0", cmd_valid, cmd_error);
      end
      rst_n = 1'b1;
      @(negedge clk);
      // R1: filter starts at broadcast, board address irrelevant
      board_addr = 16'h0BAD;
      send(8'h12, 1);
      expect_obs("R1 broadcast after reset", 1'b1, 1'b0, 8'h12, 32'h0);
      board_addr = 16'h1234;

      // sweep of all code values, back to back within a command
      for (int c = 0; c < 256; c++) begin
         logic [7:0] cc;
         int n;
         cc = 8'(c);
         n  = exp_len(cc);
         b1 = cc ^ 8'h5A; b2 = ~cc; b3 = 8'h3C;
         if (cc == 8'h40) begin b1 = 8'hFF; b2 = 8'hFF; end
         if (n < 0) begin
            send(cc, 1);
            expect_obs("R6 unknown code", 1'b0, 1'b1, 8'h00, 32'h0);
         end else if (n == 0) begin
            send(cc, 1);
            expect_obs("R2 no-payload code", 1'b1, 1'b0, cc, 32'h0);
         end else if (n == 2) begin
            send(cc, 0); expect_quiet("R11 code byte of short command");
            send(b1, 0); expect_quiet("R11 first payload byte");
            send(b2, 1);
            ep = {16'h0, b1, b2};
            expect_obs(cc == 8'h40 ? "R7 address command" : "R4 short payload",
                       1'b1, 1'b0, cc, ep);
         end else begin
            send(cc, 0); expect_quiet("R11 code byte of long command");
            send(b1, 0); expect_quiet("R11 payload byte 1");
            send(b2, 0); expect_quiet("R11 payload byte 2");
            send(b3, 0); expect_quiet("R11 payload byte 3");
            send(cc, 1);
            expect_obs("R3 long payload", 1'b1, 1'b0, cc, {b1, b2, b3, cc});
         end
      end

      // R6: byte after an unknown code is a fresh code
      send(8'hA7, 0); expect_obs("R6 unknown", 1'b0, 1'b1, 8'h00, 32'h0);
      send(8'h13, 1); expect_obs("R6 next byte decoded", 1'b1, 1'b0, 8'h13, 32'h0);

      // R5: gaps inside a long payload
      send(8'h10, 2); expect_quiet("R5 code then gap");
      send(8'hDE, 3); expect_quiet("R5 byte1 then gap");
      send(8'hAD, 1); expect_quiet("R5 byte2 then gap");
      send(8'hBE, 4); expect_quiet("R5 byte3 then gap");
      send(8'hEF, 1); expect_obs("R5 gapped payload", 1'b1, 1'b0, 8'h10, 32'hDEADBEEF);

      // R10: target equal to board address passes
      send(8'h40, 0); send(8'h12, 0); send(8'h34, 1);
      expect_obs("R7 address to this board", 1'b1, 1'b0, 8'h40, 32'h00001234);
      send(8'h32, 1); expect_obs("R10 matching target", 1'b1, 1'b0, 8'h32, 32'h0);

      // R8: other target suppresses ordinary commands
      send(8'h40, 0); send(8'hAB, 0); send(8'hCD, 1);
      expect_obs("R7 address to other board", 1'b1, 1'b0, 8'h40, 32'h0000ABCD);
      send(8'h12, 1); expect_quiet("R8 no-payload suppressed");
      send(8'h30, 0); send(8'h00, 0); send(8'h0F, 1);
      expect_quiet("R8 mask command suppressed");
      send(8'h10, 0); send(8'h01, 0); send(8'h02, 0); send(8'h03, 0); send(8'h04, 1);
      expect_quiet("R8 run number suppressed");
      send(8'h99, 1); expect_obs("R8 unknown still flagged", 1'b0, 1'b1, 8'h00, 32'h0);
      // R9: sync passes and restores broadcast
      send(8'h11, 1); expect_obs("R9 sync passes", 1'b1, 1'b0, 8'h11, 32'h0);
      send(8'h33, 1); expect_obs("R9 broadcast restored", 1'b1, 1'b0, 8'h33, 32'h0);

      // R10: explicit broadcast target
      send(8'h40, 0); send(8'hAB, 0); send(8'hCD, 0);
      send(8'h40, 0); send(8'hFF, 0); send(8'hFF, 1);
      expect_obs("R7 broadcast address", 1'b1, 1'b0, 8'h40, 32'h0000FFFF);
      send(8'h31, 0); send(8'h80, 0); send(8'h01, 1);
      expect_obs("R10 broadcast target", 1'b1, 1'b0, 8'h31, 32'h00008001);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule